// File: doc/BRIEF.md
# Inverting Bidirectional Latched Transceiver

This block sits between two parallel buses, side A and side B. It keeps one bank of storage for data that moves from A to B and a second bank for data that moves from B to A. Each bank has three controls of its own, all active low: a direction enable, a latch enable and an output enable. The direction enable is the upper level of control. While it is high, the bank cannot load and its outputs cannot drive. The latch enable and the output enable only take effect while the direction enable is low. Data is inverted on its way through the block.

The block is a synchronous sampled model. A bank is open when its direction enable and its latch enable are both low. On each rising clock edge an open bank loads the live input bus, so the output follows the input one cycle later. When either enable goes high, the bank closes. It then keeps the value it loaded on the last edge at which it was open. This covers both ways of capturing data: a rising latch enable and a rising direction enable.

No true tri-state pins are used. Each bus side has an input vector, an output vector and one output-enable bit, and the surrounding logic resolves them into a shared bus. The output vector always shows the inverse of its bank. The output-enable bit decides whether that value is driven.

Top module: `inv_latch_xcvr`

## Requirements
- R1: While rst_n is low, both banks clear to zero at the clock edge. After reset, b_out and a_out therefore read all ones.
- R2: At a rising clock edge where ab_en_n and ab_le_n are both low, the A-to-B bank loads a_in. From the next cycle on, b_out equals the bitwise inverse of that value.
- R3: At a rising clock edge where ab_en_n or ab_le_n is high, the A-to-B bank keeps its value and b_out does not change. This is how a rising ab_le_n or a rising ab_en_n captures the data.
- R4: b_oe is 1 exactly when ab_en_n and ab_oe_n are both low, whatever ab_le_n is. When b_oe is 0, the B bus is high impedance.
- R5: At a rising clock edge where ba_en_n and ba_le_n are both low, the B-to-A bank loads b_in. From the next cycle on, a_out equals the bitwise inverse of that value.
- R6: At a rising clock edge where ba_en_n or ba_le_n is high, the B-to-A bank keeps its value and a_out does not change.
- R7: a_oe is 1 exactly when ba_en_n and ba_oe_n are both low, whatever ba_le_n is.
- R8: The two directions are independent. The A-to-B controls and a_in never change a_out or a_oe, and the B-to-A controls and b_in never change b_out or b_oe. Both banks can load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Value present on the A bus |
| a_out | output | W | Inverted B-to-A bank contents |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | W | Value present on the B bus |
| b_out | output | W | Inverted A-to-B bank contents |
| b_oe | output | 1 | Drive enable for the B bus |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The assertions check two things on every cycle in each direction. First, an open bank shows the inverse of the sampled input one cycle later. Second, a closed bank leaves its output unchanged. Other behaviour is shown only by the bench's scenarios:
- the reset value;
- the output-enable gating, including a latch enable that has no effect on driving;
- capture by a rising direction enable rather than a rising latch enable;
- independence of the two directions when both are used at the same time.

The bench also resolves each bus and flags contention when the block and an outside driver are both active.

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_en_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_en_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_open, ba_open;

  assign ab_open = ~ab_en_n & ~ab_le_n;
  assign ba_open = ~ba_en_n & ~ba_le_n;

  always_ff @(posedge clk) begin
    if (!rst_n) ab_q <= '0;
    else if (ab_open) ab_q <= a_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ba_q <= '0;
    else if (ba_open) ba_q <= b_in;
  end

  assign b_out = ~ab_q;
  assign a_out = ~ba_q;
  assign b_oe  = ~ab_en_n & ~ab_oe_n;
  assign a_oe  = ~ba_en_n & ~ba_oe_n;

  a_r2_ab_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ab_le_n) |=> (b_out == ~$past(a_in)));
  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_en_n || ab_le_n) |=> $stable(b_out));
  a_r5_ba_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_en_n && !ba_le_n) |=> (a_out == ~$past(b_in)));
  a_r6_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_en_n || ba_le_n) |=> $stable(a_out));

endmodule

// File: tb/inv_latch_xcvr_tb.sv
module inv_latch_xcvr_tb;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic ab_en_n = 1, ab_le_n = 1, ab_oe_n = 1;
  logic ba_en_n = 1, ba_le_n = 1, ba_oe_n = 1;
  int checks = 0, fails = 0;
  logic [W-1:0] ref_ab = '0, ref_ba = '0;
  logic ab_loaded = 0, ba_loaded = 0;

  always #5 clk = ~clk;

  inv_latch_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n));

  function automatic logic exp_oe(logic en_n, logic oe_n);
    return !en_n && !oe_n;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all();
    chk(ab_loaded ? "R2 b_out" : "R3/R8 b_out", b_out, ~ref_ab);
    chk(ba_loaded ? "R5 a_out" : "R6/R8 a_out", a_out, ~ref_ba);
    chk("R4 b_oe", W'(b_oe), W'(exp_oe(ab_en_n, ab_oe_n)));
    chk("R7 a_oe", W'(a_oe), W'(exp_oe(ba_en_n, ba_oe_n)));
  endtask

  // apply at negedge, check after the following posedge (at next negedge)
  task automatic step(logic [W-1:0] ai, logic [W-1:0] bi,
                      logic [2:0] ab, logic [2:0] ba);
    logic ext_a, ext_b;
    a_in = ai; b_in = bi;
    {ab_en_n, ab_le_n, ab_oe_n} = ab;
    {ba_en_n, ba_le_n, ba_oe_n} = ba;
    #1;
    // outside drivers are active when the bench expects the block idle
    ext_a = !exp_oe(ba_en_n, ba_oe_n);
    ext_b = !exp_oe(ab_en_n, ab_oe_n);
    checks++;
    if ((a_oe && ext_a) || (b_oe && ext_b)) begin
      fails++;
      $display("FAIL R4/R7 bus contention actual=%b%b expected=00",
               a_oe && ext_a, b_oe && ext_b);
    end
    ab_loaded = !ab[2] && !ab[1];
    ba_loaded = !ba[2] && !ba[1];
    if (ab_loaded) ref_ab = ai;
    if (ba_loaded) ref_ba = bi;
    @(negedge clk);
    chk_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 b_out", b_out, '1);
    chk("R1 a_out", a_out, '1);
    chk("R1 b_oe", W'(b_oe), '0);
    chk("R1 a_oe", W'(a_oe), '0);
    rst_n = 1;
    // R2 transparent A->B, R4 enabled
    step(8'h3C, 8'h00, 3'b000, 3'b111);
    step(8'hA5, 8'h00, 3'b000, 3'b111);
    // R3 capture on rising LE: A changes, b_out holds
    step(8'h11, 8'h00, 3'b010, 3'b111);
    chk("R3 le capture", b_out, ~8'hA5);
    // R3 capture on rising E with LE low
    step(8'h5A, 8'h00, 3'b000, 3'b111);
    step(8'hFF, 8'h00, 3'b100, 3'b111);
    chk("R3 en capture", b_out, ~8'h5A);
    // R4 oe disabled while loading
    step(8'h0F, 8'h00, 3'b001, 3'b111);
    // R5/R6/R7 B->A direction
    step(8'h00, 8'h96, 3'b111, 3'b000);
    step(8'h00, 8'h42, 3'b111, 3'b010);
    chk("R6 le capture", a_out, ~8'h96);
    // R8 both directions at once
    step(8'hC3, 8'h24, 3'b000, 3'b000);
    chk("R8 both ab", b_out, ~8'hC3);
    chk("R8 both ba", a_out, ~8'h24);
    // random mix
    for (int i = 0; i < 2000; i++)
      step(W'($urandom), W'($urandom), 3'($urandom), 3'($urandom));
    // reset mid-run, R1
    rst_n = 0;
    @(negedge clk);
    chk("R1 re-reset b_out", b_out, '1);
    chk("R1 re-reset a_out", a_out, '1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule